// File: doc/BRIEF.md
# Minimum On-Time Switching Controller

This block is the digital control core of a synchronous step-down converter that regulates with a hysteretic, minimum-on-time loop. A regulation comparator outside the block reports that the output has fallen below its target. The controller answers by turning on the high-side switch for at least a programmed number of clocks. It keeps the switch on for as long as the output stays low. It then hands the inductor to the low-side switch for an off-time during which new requests are ignored. An overcurrent report cuts the high-side pulse short and stretches the following off-time. An undervoltage or thermal fault parks both switches off.

All timing is given in clock cycles on register inputs: the minimum on-time, the normal off-time, the off-time after overcurrent, and a dead-time that separates the two drives. The four status flags arrive asynchronously and are synchronized inside the block. A three-bit state code is provided for observation.

Top module: `mot_switch_ctrl`

## Requirements
- R1: While reset is asserted both drives are off and the state code is 0 (hold). Once reset is released and no fault is present, the state code becomes 1 (wait) and the low-side drive turns on.
- R2: A charge request is taken only on a rising edge of the synchronized output-low flag, only in state 1 (wait), and only when the synchronized overcurrent flag is clear. An edge during an off-time is ignored. An edge while overcurrent is set is ignored. An output-low level that is still high when an off-time ends starts nothing.
- R3: An accepted request passes through state 2 with both drives off for the dead-time. It then enters state 3, where the high-side drive is on and the minimum on-time count starts.
- R4: Without overcurrent or fault, the high-side pulse lasts max(M, T) cycles. M is the effective minimum on-time. T is the time until the synchronized output-low flag clears. If the output-low input is held high for H cycles, then T = H minus the effective dead-time. A sustained low output therefore gives a continuous high-side pulse.
- R5: A normally ended pulse is followed by state 4 (both drives off) for the dead-time. Next comes state 5 with the low-side drive on for the normal off-time. The block then returns to state 1.
- R6: Synchronized overcurrent during state 3 or state 2 ends the charge at the next clock, even before the minimum on-time has elapsed. The following off-time in state 5 uses the overcurrent off-time count.
- R7: A synchronized undervoltage or thermal fault forces state 0 with both drives off at the next clock. Requests are ignored until the fault clears. The block then resumes in state 1.
- R8: The two drives are never on together. Every hand-over between them has at least one clock with both off.
- R9: Any timing input programmed to zero behaves as one cycle.
- R10: Each flag input passes through two flip-flops. A request raised on the input just after a clock edge enters state 2 at the third following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| outLowAsync | input | 1 | Output-below-regulation flag from the comparator |
| overCurAsync | input | 1 | Inductor overcurrent flag |
| uvloAsync | input | 1 | Undervoltage lockout flag |
| thermAsync | input | 1 | Thermal shutdown flag |
| minOnCnt | input | CNT_W | Minimum on-time in cycles |
| blankCnt | input | CNT_W | Normal off-time in cycles |
| ocOffCnt | input | CNT_W | Off-time after overcurrent in cycles |
| deadCnt | input | CNT_W | Dead-time between drives in cycles |
| hiDrive | output | 1 | High-side switch enable |
| loDrive | output | 1 | Low-side switch enable |
| ctrlState | output | 3 | State code: 0 hold, 1 wait, 2 pre-charge dead, 3 charge, 4 post-charge dead, 5 off-time |

## Verification
The minimum-on property assumes that `minOnCnt` does not change while a pulse is running. The bench only reprograms the timing inputs while the controller sits in the wait state. The checks also assume each flag holds its level for at least two clocks, so that the synchronizers pass every change. The stimulus holds every flag for two or more cycles, and it raises faults and overcurrent only at chosen points of the sequence.

// File: rtl/mot_pkg.sv
package mot_pkg;
  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_PRE    = 3'd2,
    ST_CHARGE = 3'd3,
    ST_POST   = 3'd4,
    ST_OFF    = 3'd5
  } ctrlState_e;

  typedef enum logic [1:0] {
    SEL_MINON = 2'd0,
    SEL_BLANK = 2'd1,
    SEL_OCOFF = 2'd2
  } phaseSel_e;

  typedef struct packed {
    logic      deadLoad;
    logic      phaseLoad;
    phaseSel_e phaseSel;
  } tmrCmd_t;

  localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/mot_sync.sv
module mot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/mot_timer.sv
module mot_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         done
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] count;
  logic [W-1:0] startVal;

  // zero is stretched to a single cycle
  assign startVal = (loadVal == '0) ? ONE : loadVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (load)         count <= startVal;
    else if (count > ONE)  count <= count - ONE;
  end

  assign done = (count <= ONE);
endmodule

// File: rtl/mot_dp.sv
module mot_dp
  import mot_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             outLowAsync,
  input  logic             overCurAsync,
  input  logic             uvloAsync,
  input  logic             thermAsync,
  input  logic [CNT_W-1:0] minOnCnt,
  input  logic [CNT_W-1:0] blankCnt,
  input  logic [CNT_W-1:0] ocOffCnt,
  input  logic [CNT_W-1:0] deadCnt,
  input  tmrCmd_t          cmd,
  output logic             outLowS,
  output logic             outLowRise,
  output logic             overCurS,
  output logic             faultS,
  output logic             deadDone,
  output logic             phaseDone
);
  logic [NUM_FLAGS-1:0] rawFlags;
  logic [NUM_FLAGS-1:0] syncFlags;
  logic                 outLowPrev;
  logic [CNT_W-1:0]     phaseVal;

  assign rawFlags = {thermAsync, uvloAsync, overCurAsync, outLowAsync};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_sync
    mot_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .d   (rawFlags[i]),
      .q   (syncFlags[i])
    );
  end

  assign outLowS  = syncFlags[0];
  assign overCurS = syncFlags[1];
  assign faultS   = syncFlags[2] | syncFlags[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outLowPrev <= 1'b0;
    else       outLowPrev <= outLowS;
  end

  assign outLowRise = outLowS & ~outLowPrev;

  always_comb begin
    case (cmd.phaseSel)
      SEL_BLANK: phaseVal = blankCnt;
      SEL_OCOFF: phaseVal = ocOffCnt;
      default:   phaseVal = minOnCnt;
    endcase
  end

  mot_timer #(.W(CNT_W)) u_deadTmr (
    .clk    (clk),
    .rstN   (rstN),
    .load   (cmd.deadLoad),
    .loadVal(deadCnt),
    .done   (deadDone)
  );

  mot_timer #(.W(CNT_W)) u_phaseTmr (
    .clk    (clk),
    .rstN   (rstN),
    .load   (cmd.phaseLoad),
    .loadVal(phaseVal),
    .done   (phaseDone)
  );
endmodule

// File: rtl/mot_fsm.sv
module mot_fsm
  import mot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       outLowS,
  input  logic       outLowRise,
  input  logic       overCurS,
  input  logic       faultS,
  input  logic       deadDone,
  input  logic       phaseDone,
  output tmrCmd_t    cmd,
  output logic       hiDrive,
  output logic       loDrive,
  output logic [2:0] stateCode
);
  ctrlState_e state, nextState;
  logic       ocLatched, ocNext;

  always_comb begin
    nextState     = state;
    ocNext        = ocLatched;
    cmd.deadLoad  = 1'b0;
    cmd.phaseLoad = 1'b0;
    cmd.phaseSel  = SEL_MINON;
    if (faultS) begin
      nextState = ST_HOLD;
    end else begin
      case (state)
        ST_HOLD: nextState = ST_WAIT;
        ST_WAIT: begin
          if (outLowRise && !overCurS) begin
            nextState    = ST_PRE;
            cmd.deadLoad = 1'b1;
          end
        end
        ST_PRE: begin
          if (overCurS) begin
            nextState    = ST_POST;
            cmd.deadLoad = 1'b1;
            ocNext       = 1'b1;
          end else if (deadDone) begin
            nextState     = ST_CHARGE;
            cmd.phaseLoad = 1'b1;
            cmd.phaseSel  = SEL_MINON;
          end
        end
        ST_CHARGE: begin
          if (overCurS) begin
            nextState    = ST_POST;
            cmd.deadLoad = 1'b1;
            ocNext       = 1'b1;
          end else if (phaseDone && !outLowS) begin
            nextState    = ST_POST;
            cmd.deadLoad = 1'b1;
            ocNext       = 1'b0;
          end
        end
        ST_POST: begin
          if (deadDone) begin
            nextState     = ST_OFF;
            cmd.phaseLoad = 1'b1;
            cmd.phaseSel  = ocLatched ? SEL_OCOFF : SEL_BLANK;
          end
        end
        ST_OFF: begin
          if (phaseDone) nextState = ST_WAIT;
        end
        default: nextState = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HOLD;
      ocLatched <= 1'b0;
    end else begin
      state     <= nextState;
      ocLatched <= ocNext;
    end
  end

  assign hiDrive   = (state == ST_CHARGE);
  assign loDrive   = (state == ST_WAIT) || (state == ST_OFF);
  assign stateCode = state;
endmodule

// File: rtl/mot_switch_ctrl.sv
module mot_switch_ctrl
  import mot_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             outLowAsync,
  input  logic             overCurAsync,
  input  logic             uvloAsync,
  input  logic             thermAsync,
  input  logic [CNT_W-1:0] minOnCnt,
  input  logic [CNT_W-1:0] blankCnt,
  input  logic [CNT_W-1:0] ocOffCnt,
  input  logic [CNT_W-1:0] deadCnt,
  output logic             hiDrive,
  output logic             loDrive,
  output logic [2:0]       ctrlState
);
  tmrCmd_t cmd;
  logic    outLowS, outLowRise, overCurS, faultS, deadDone, phaseDone;

  mot_dp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .outLowAsync (outLowAsync),
    .overCurAsync(overCurAsync),
    .uvloAsync   (uvloAsync),
    .thermAsync  (thermAsync),
    .minOnCnt    (minOnCnt),
    .blankCnt    (blankCnt),
    .ocOffCnt    (ocOffCnt),
    .deadCnt     (deadCnt),
    .cmd         (cmd),
    .outLowS     (outLowS),
    .outLowRise  (outLowRise),
    .overCurS    (overCurS),
    .faultS      (faultS),
    .deadDone    (deadDone),
    .phaseDone   (phaseDone)
  );

  mot_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .outLowS   (outLowS),
    .outLowRise(outLowRise),
    .overCurS  (overCurS),
    .faultS    (faultS),
    .deadDone  (deadDone),
    .phaseDone (phaseDone),
    .cmd       (cmd),
    .hiDrive   (hiDrive),
    .loDrive   (loDrive),
    .stateCode (ctrlState)
  );
endmodule

// File: rtl/mot_switch_ctrl_chk.sv
module mot_switch_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             hiDrive,
  input logic             loDrive,
  input logic [2:0]       ctrlState,
  input logic             overCurS,
  input logic             faultS,
  input logic [CNT_W-1:0] minOnCnt
);
  logic [15:0] hiRun;
  logic [15:0] minEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        hiRun <= '0;
    else if (hiDrive) hiRun <= hiRun + 16'd1;
    else              hiRun <= '0;
  end

  assign minEff = (minOnCnt == '0) ? 16'd1 : 16'(minOnCnt);

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(hiDrive && loDrive));

  p_gap_to_hi_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiDrive) |-> $past(!loDrive));

  p_gap_to_lo_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loDrive) |-> $past(!hiDrive));

  p_fault_park_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultS |=> (ctrlState == 3'd0 && !hiDrive && !loDrive));

  p_oc_cut_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hiDrive && overCurS) |=> !hiDrive);

  p_min_on_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(hiDrive) && !$past(overCurS) && !$past(faultS)) |-> (hiRun >= minEff));

  p_oc_blocks_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == 3'd1 && overCurS) |=> (ctrlState != 3'd2));
endmodule

bind mot_switch_ctrl mot_switch_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hiDrive  (hiDrive),
  .loDrive  (loDrive),
  .ctrlState(ctrlState),
  .overCurS (overCurS),
  .faultS   (faultS),
  .minOnCnt (minOnCnt)
);

// File: tb/mot_switch_ctrl_tb.sv
`timescale 1ns/1ps
module mot_switch_ctrl_tb;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             outLowAsync = 1'b0;
  logic             overCurAsync = 1'b0;
  logic             uvloAsync = 1'b0;
  logic             thermAsync = 1'b0;
  logic [CNT_W-1:0] minOnCnt = 8'd5;
  logic [CNT_W-1:0] blankCnt = 8'd3;
  logic [CNT_W-1:0] ocOffCnt = 8'd12;
  logic [CNT_W-1:0] deadCnt  = 8'd2;
  logic             hiDrive, loDrive;
  logic [2:0]       ctrlState;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct { int hiLen; int gapLen; int offLen; } item_t;
  item_t expQ[$];
  string reqQ[$];

  int hiCycles = 0;
  int hiPulses = 0;
  int monPhase = 0;
  int mHi = 0, mGap = 0, mOff = 0;

  always #10 clk = ~clk;

  mot_switch_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .outLowAsync(outLowAsync), .overCurAsync(overCurAsync),
    .uvloAsync(uvloAsync), .thermAsync(thermAsync),
    .minOnCnt(minOnCnt), .blankCnt(blankCnt), .ocOffCnt(ocOffCnt), .deadCnt(deadCnt),
    .hiDrive(hiDrive), .loDrive(loDrive), .ctrlState(ctrlState)
  );

  task automatic check(string req, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectPulse(string req, int hiLen, int gapLen, int offLen);
    item_t it;
    it.hiLen = hiLen; it.gapLen = gapLen; it.offLen = offLen;
    expQ.push_back(it);
    reqQ.push_back(req);
  endtask

  // monitor: measures high pulse, dead gap and off-time, compares to queue
  always @(negedge clk) begin
    if (rstN) begin
      if (hiDrive) hiCycles++;
      if (ctrlState == 3'd0) monPhase = 0;
      case (monPhase)
        0: if (hiDrive) begin monPhase = 1; mHi = 1; hiPulses++; end
        1: if (hiDrive) mHi++; else begin monPhase = 2; mGap = 1; end
        2: if (!loDrive) mGap++;
           else begin monPhase = 3; mOff = (ctrlState == 3'd5) ? 1 : 0; end
        3: if (ctrlState == 3'd5) mOff++;
           else begin
             monPhase = 0;
             if (expQ.size() == 0) begin
               check("R2", "unexpected pulse count", 1, 0);
             end else begin
               item_t e;
               string r;
               e = expQ.pop_front();
               r = reqQ.pop_front();
               check(r, "high pulse length", mHi, e.hiLen);
               check("R8", "dead gap length", mGap, e.gapLen);
               check(r, "off-time length", mOff, e.offLen);
             end
           end
        default: monPhase = 0;
      endcase
    end
  end

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    int base;
    int pulses;
    // R1 reset state
    waitCycles(3);
    check("R1", "hiDrive in reset", int'(hiDrive), 0);
    check("R1", "loDrive in reset", int'(loDrive), 0);
    check("R1", "state in reset", int'(ctrlState), 0);
    rstN = 1'b1;
    waitCycles(5);
    check("R1", "state after reset", int'(ctrlState), 1);
    check("R1", "loDrive after reset", int'(loDrive), 1);

    // R3 R4 R10: short request, minimum on-time dominates
    expectPulse("R4", 5, 2, 3);
    outLowAsync = 1'b1; waitCycles(2); outLowAsync = 1'b0;
    waitCycles(40);

    // R4: sustained request, H=20 -> 20-2
    expectPulse("R4", 18, 2, 3);
    outLowAsync = 1'b1; waitCycles(20); outLowAsync = 1'b0;
    waitCycles(40);

    // R6: overcurrent cuts pulse at 4 (< min-on 5), long off-time; R2 held level
    pulses = hiPulses;
    expectPulse("R6", 4, 2, 12);
    outLowAsync = 1'b1; waitCycles(6);
    overCurAsync = 1'b1; waitCycles(3); overCurAsync = 1'b0;
    waitCycles(21); outLowAsync = 1'b0;
    waitCycles(30);
    check("R2", "pulses with level held after off-time", hiPulses - pulses, 1);

    // R9: all timers zero act as one cycle
    minOnCnt = 0; blankCnt = 0; deadCnt = 0; ocOffCnt = 0;
    expectPulse("R9", 1, 1, 1);
    outLowAsync = 1'b1; waitCycles(2); outLowAsync = 1'b0;
    waitCycles(20);

    // R5 R2: normal off-time of 10, edge during off-time ignored
    minOnCnt = 5; blankCnt = 10; deadCnt = 2; ocOffCnt = 12;
    pulses = hiPulses;
    expectPulse("R5", 5, 2, 10);
    outLowAsync = 1'b1; waitCycles(2); outLowAsync = 1'b0;
    waitCycles(12);
    outLowAsync = 1'b1; waitCycles(2); outLowAsync = 1'b0;
    waitCycles(40);
    check("R2", "pulses with edge during off-time", hiPulses - pulses, 1);
    check("R5", "state after off-time", int'(ctrlState), 1);

    // R2: overcurrent present at edge blocks start
    base = hiCycles;
    overCurAsync = 1'b1; waitCycles(4);
    outLowAsync = 1'b1; waitCycles(3); outLowAsync = 1'b0;
    waitCycles(6); overCurAsync = 1'b0;
    waitCycles(20);
    check("R2", "high cycles with overcurrent at edge", hiCycles - base, 0);
    check("R2", "state after blocked request", int'(ctrlState), 1);

    // R7: undervoltage during charge parks both drives
    outLowAsync = 1'b1; waitCycles(8);
    check("R7", "hiDrive before fault", int'(hiDrive), 1);
    uvloAsync = 1'b1; waitCycles(4);
    check("R7", "hiDrive in fault", int'(hiDrive), 0);
    check("R7", "loDrive in fault", int'(loDrive), 0);
    check("R7", "state in fault", int'(ctrlState), 0);
    base = hiCycles;
    outLowAsync = 1'b0; waitCycles(3);
    outLowAsync = 1'b1; waitCycles(3); outLowAsync = 1'b0;
    waitCycles(5);
    check("R7", "high cycles during fault", hiCycles - base, 0);
    uvloAsync = 1'b0; waitCycles(5);
    check("R7", "state after fault clears", int'(ctrlState), 1);
    check("R7", "loDrive after fault clears", int'(loDrive), 1);

    // R7: thermal fault from wait
    thermAsync = 1'b1; waitCycles(4);
    check("R7", "state in thermal fault", int'(ctrlState), 0);
    check("R7", "loDrive in thermal fault", int'(loDrive), 0);
    thermAsync = 1'b0; waitCycles(5);
    check("R7", "state after thermal clears", int'(ctrlState), 1);

    // R10: exact latency to pre-charge state
    outLowAsync = 1'b1; waitCycles(2);
    check("R10", "state two clocks after request", int'(ctrlState), 1);
    waitCycles(1);
    check("R10", "state three clocks after request", int'(ctrlState), 2);
    check("R3", "drives off in pre-charge", int'(hiDrive) + int'(loDrive), 0);
    waitCycles(2);
    check("R3", "state after dead-time", int'(ctrlState), 3);
    check("R3", "hiDrive in charge", int'(hiDrive), 1);
    expectPulse("R4", 5, 2, 10);
    waitCycles(1); outLowAsync = 1'b0;
    waitCycles(40);

    check("R4", "pending expected pulses", expQ.size(), 0);
    finished = 1'b1;
    finishRun();
  end
endmodule